// File: doc/BRIEF.md
# Chopper Demodulator and Decimating Demultiplexer

This block sits behind a single converter that is time-shared across several chopped input channels. Every accepted sample carries a known ±1 chopping sign. The block removes that sign in the digital domain and steers each sample to the channel it belongs to. It then averages each channel over a window of `DEC` samples, so every channel produces one result per `NCH·DEC` input samples.

The input stays on one channel for two consecutive samples, one of each polarity, and then moves on to the next channel. After the last channel it wraps to channel 0. The sample rate is twice the chopping rate, so the sign flips on every accepted sample. The sign applied to a sample lags the modulator phase by one sample, which matches the converter's one-sample latency.

A small sequencer tracks the position in the stream. It has two states: `SEQ_LEAD`, waiting for the first sample of a channel pair, and `SEQ_TRAIL`, waiting for the second. An accepted sample in `SEQ_LEAD` moves it to `SEQ_TRAIL`. An accepted sample in `SEQ_TRAIL` moves it back to `SEQ_LEAD` and steps the channel index. When the index wraps from the last channel to 0, the round counter also advances. Without an accepted sample the state holds.

When chopping is done in the analog path, a configuration bit passes samples through with no sign change.

Top module: `chop_demux_dec`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every `lane_vld` bit is 0 and every lane result is 0.
- R2: With `chop_en`=1, the first accepted sample after reset is negated, the second is kept, and the sign keeps alternating on every accepted sample. This is the modulator's positive-first phase delayed by one sample.
- R3: Accepted samples 2c and 2c+1 of each group of 2·`NCH` belong to channel c, for c = 0 to `NCH`-1. Channel c's result lives at bits [c·(`SAMP_W`+1) +: `SAMP_W`+1] of `lane_avg`.
- R4: Each lane result equals floor(S / `DEC`), where S is the sum of that channel's `DEC` demodulated samples in the window.
- R5: `lane_vld[c]` is a one-cycle pulse in the cycle after the second sample of channel c in the last pair round of a window (window position (`DEC`/2-1)·2·`NCH`+2c+1) is accepted. At most one lane is valid in any cycle.
- R6: With `chop_en`=0, samples are accumulated unchanged, and the sign phase still advances.
- R7: Each lane's accumulator restarts from zero after it produces a result, so windows are independent.
- R8: No overflow occurs at full scale: negating −2^(`SAMP_W`−1) gives +2^(`SAMP_W`−1), and results range over the full signed (`SAMP_W`+1)-bit span.
- R9: Cycles with `smp_valid`=0 change neither the channel position, the sign phase nor any accumulator.
- R10: A synchronous reset in mid-stream realigns the next accepted sample to channel 0, first of a pair, with a negative demodulation sign, and it discards partial sums.
- R11: Each lane result holds its value between its valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe; the sample is accepted on this clock edge |
| smp_data | input | SAMP_W | Signed converter sample |
| chop_en | input | 1 | 1 = apply digital demodulation sign, 0 = bypass |
| lane_avg | output | NCH*(SAMP_W+1) | Packed signed per-channel averages, channel 0 in the low bits |
| lane_vld | output | NCH | Per-channel one-cycle result strobe |

## Verification
The bench feeds a chopped constant level into each channel and expects each level back exactly. A sign in the wrong phase, or a missing one-sample lag, would return the negated level or zero instead. It replays the same stream in bypass, where a sign applied anyway would give the level rather than zero. Full-scale patterns reach +2^(`SAMP_W`−1) after negation and −2^(`SAMP_W`−1) after flooring, which exposes accumulators that are too narrow and truncation that rounds toward zero. Idle gaps, back-to-back windows and a reset in the middle of a window catch phase counters that drift, accumulators that are not cleared, and valid pulses that arrive on the wrong lane or in the wrong cycle.

// File: rtl/cdd_pkg.sv
package cdd_pkg;

    // Position inside a channel's two-sample dwell
    typedef enum logic {
        SEQ_LEAD  = 1'b0,
        SEQ_TRAIL = 1'b1
    } seq_state_e;

endpackage

// File: rtl/cdd_seq.sv
module cdd_seq
    import cdd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DEC = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 adv,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ch_idx,
    output logic                                 is_trail,
    output logic                                 last_round,
    output logic                                 dem_neg
);

    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int ROUNDS = DEC / 2;
    localparam int RND_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

    seq_state_e       state, nxt;
    logic [RND_W-1:0] rnd;
    logic             mod_neg;   // modulator polarity of the current slot

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_LEAD:  nxt = SEQ_TRAIL;
            SEQ_TRAIL: nxt = SEQ_LEAD;
            default:   nxt = SEQ_LEAD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= SEQ_LEAD;
        else if (adv)
            state <= nxt;
    end

    // channel, round and chop phase tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            ch_idx  <= '0;
            rnd     <= '0;
            mod_neg <= 1'b0;      // modulator starts positive
            dem_neg <= 1'b1;      // sample in hand came from the slot before
        end else if (adv) begin
            mod_neg <= ~mod_neg;
            dem_neg <= mod_neg;   // one-sample lag behind the modulator
            if (state == SEQ_TRAIL) begin
                if (ch_idx == CH_W'(NCH - 1)) begin
                    ch_idx <= '0;
                    rnd    <= (rnd == RND_W'(ROUNDS - 1)) ? '0 : rnd + 1'b1;
                end else begin
                    ch_idx <= ch_idx + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        is_trail   = (state == SEQ_TRAIL);
        last_round = (rnd == RND_W'(ROUNDS - 1));
    end

    AST_SIGN_LAG: assert property (@(posedge clk) disable iff (rst)
        adv |=> (dem_neg == $past(mod_neg)));                       // R2
    AST_SIGN_ALT: assert property (@(posedge clk) disable iff (rst)
        adv |=> (dem_neg != $past(dem_neg)));                       // R2
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(ch_idx) && $stable(state) && $stable(dem_neg) && $stable(rnd))); // R9
    AST_CH_RANGE: assert property (@(posedge clk) disable iff (rst)
        ch_idx <= CH_W'(NCH - 1));                                  // R3

endmodule

// File: rtl/cdd_demod.sv
module cdd_demod #(
    parameter int SAMP_W = 12
) (
    input  logic [SAMP_W-1:0] sample,
    input  logic              neg,
    input  logic              chop_en,
    output logic [SAMP_W:0]   dout
);

    logic [SAMP_W:0] ext;

    always_comb begin
        ext  = {sample[SAMP_W-1], sample};
        dout = (chop_en && neg) ? (~ext + 1'b1) : ext;
    end

endmodule

// File: rtl/cdd_lane.sv
module cdd_lane #(
    parameter int OUT_W = 13,
    parameter int SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             fire,
    input  logic [OUT_W-1:0] din,
    output logic [OUT_W-1:0] res,
    output logic             res_vld
);

    localparam int ACC_W = OUT_W + SHIFT;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    always_comb sum = acc + {{SHIFT{din[OUT_W-1]}}, din};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            res     <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= 1'b0;
            if (take) begin
                if (fire) begin
                    res     <= sum[ACC_W-1:SHIFT];  // floor divide by 2^SHIFT
                    acc     <= '0;
                    res_vld <= 1'b1;
                end else begin
                    acc <= sum;
                end
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_vld |=> !res_vld);                                      // R5
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> $stable(res));                                 // R11
    AST_ACC_EMPTY: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (acc == '0));                                   // R7

endmodule

// File: rtl/chop_demux_dec.sv
module chop_demux_dec #(
    parameter int NCH    = 4,
    parameter int DEC    = 4,
    parameter int SAMP_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic [SAMP_W-1:0]         smp_data,
    input  logic                      chop_en,
    output logic [NCH*(SAMP_W+1)-1:0] lane_avg,
    output logic [NCH-1:0]            lane_vld
);

    // DEC must be an even power of two (2, 4, 8, ...)
    localparam int OUT_W = SAMP_W + 1;
    localparam int SHIFT = $clog2(DEC);
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CH_W-1:0]  ch_idx;
    logic             is_trail;
    logic             last_round;
    logic             dem_neg;
    logic [OUT_W-1:0] dsample;
    logic             window_end;

    cdd_seq #(.NCH(NCH), .DEC(DEC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .adv        (smp_valid),
        .ch_idx     (ch_idx),
        .is_trail   (is_trail),
        .last_round (last_round),
        .dem_neg    (dem_neg)
    );

    cdd_demod #(.SAMP_W(SAMP_W)) u_demod (
        .sample  (smp_data),
        .neg     (dem_neg),
        .chop_en (chop_en),
        .dout    (dsample)
    );

    always_comb window_end = is_trail && last_round;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic take_c;
        always_comb take_c = smp_valid && (ch_idx == CH_W'(c));

        cdd_lane #(.OUT_W(OUT_W), .SHIFT(SHIFT)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .take    (take_c),
            .fire    (window_end),
            .din     (dsample),
            .res     (lane_avg[c*OUT_W +: OUT_W]),
            .res_vld (lane_vld[c])
        );
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_vld));                                        // R5

endmodule

// File: tb/chop_demux_dec_test.sv
module chop_demux_dec_test;

    localparam int NCH = 4;
    localparam int DEC = 4;
    localparam int SW  = 12;
    localparam int OW  = SW + 1;
    localparam int SH  = 2;
    localparam int WIN = NCH * DEC;

    logic              clk = 1'b0;
    logic              rst;
    logic              smp_valid;
    logic [SW-1:0]     smp_data;
    logic              chop_en;
    logic [NCH*OW-1:0] lane_avg;
    logic [NCH-1:0]    lane_vld;

    int errs   = 0;
    int checks = 0;
    int n_idx;
    int sums [NCH];
    int hold [NCH];
    int unsigned lcg = 32'd12345;

    chop_demux_dec #(.NCH(NCH), .DEC(DEC), .SAMP_W(SW)) uut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .chop_en   (chop_en),
        .lane_avg  (lane_avg),
        .lane_vld  (lane_vld)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lane(input int c);
        logic [OW-1:0] s;
        s = lane_avg[c*OW +: OW];
        return int'($signed(s));
    endfunction

    function automatic int next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'((lcg >> 12) & 32'hfff) - 2048;
    endfunction

    task automatic model_clear();
        n_idx = 0;
        for (int c = 0; c < NCH; c++) begin
            sums[c] = 0;
            hold[c] = 0;
        end
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // drive one sample at a falling edge, check all lanes at the next one
    task automatic push(input int v, input bit en, input string tag);
        int  sgn, ch, pos;
        bit  fire;
        smp_data  = SW'(v);
        chop_en   = en;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        sgn = (en && (n_idx % 2 == 0)) ? -1 : 1;
        ch  = (n_idx / 2) % NCH;
        pos = n_idx % WIN;
        sums[ch] += sgn * v;
        fire = (pos >= WIN - 2 * NCH) && (pos % 2 == 1);
        if (fire) begin
            hold[ch] = sums[ch] >>> SH;
            sums[ch] = 0;
        end
        n_idx++;
        for (int c = 0; c < NCH; c++) begin
            chk(lane_vld[c] == (fire && c == ch), "R5 valid timing", int'(lane_vld[c]),
                int'(fire && c == ch));
            chk(lane(c) == hold[c], tag, lane(c), hold[c]);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                chk(lane_vld[c] == 1'b0, "R9 idle valid", int'(lane_vld[c]), 0);
                chk(lane(c) == hold[c], "R11 hold", lane(c), hold[c]);
            end
        end
    endtask

    function automatic int dc_of(input int c);
        return 100 * (c + 1) - 250;
    endfunction

    initial begin
        rst       = 1'b1;
        smp_valid = 1'b0;
        smp_data  = '0;
        chop_en   = 1'b1;
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            chk(lane_vld[c] == 1'b0, "R1 reset valid", int'(lane_vld[c]), 0);
            chk(lane(c) == 0, "R1 reset data", lane(c), 0);
        end
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        for (int c = 0; c < NCH; c++)
            chk(lane_vld[c] == 1'b0, "R1 after release", int'(lane_vld[c]), 0);

        // R2: chopped constant per channel comes back as the constant
        for (int n = 0; n < 2 * WIN; n++) begin
            int d;
            d = dc_of((n / 2) % NCH);
            push((n % 2 == 0) ? -d : d, 1'b1, "R2 chopped dc");
        end
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == dc_of(c), "R2 dc level", lane(c), dc_of(c));

        // R6: the same stream in bypass averages to zero
        for (int n = 0; n < WIN; n++) begin
            int d;
            d = dc_of((n / 2) % NCH);
            push((n % 2 == 0) ? -d : d, 1'b0, "R6 bypass");
        end
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == 0, "R6 bypass level", lane(c), 0);

        // R3/R4/R7: pseudo-random full-range samples, back-to-back windows
        for (int n = 0; n < 4 * WIN; n++)
            push(next_rand(), 1'b1, "R3 R4 R7 random");

        // R8: full-scale extremes
        for (int n = 0; n < WIN; n++)
            push((n % 2 == 0) ? -2048 : 2047, 1'b1, "R8 high");
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == 2047, "R8 high level", lane(c), 2047);
        for (int n = 0; n < WIN; n++)
            push((n % 2 == 0) ? 2047 : -2048, 1'b1, "R8 low");
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == -2048, "R8 low level", lane(c), -2048);
        for (int n = 0; n < WIN; n++)
            push(-2048, 1'b0, "R8 bypass min");
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == -2048, "R8 bypass min level", lane(c), -2048);

        // R9/R11: gaps between samples
        for (int n = 0; n < 2 * WIN; n++) begin
            push(next_rand(), 1'b1, "R9 gapped");
            idle((n % 3) + 1);
        end

        // R10: reset in the middle of a window
        for (int n = 0; n < 5; n++)
            push(next_rand(), 1'b1, "R10 pre-reset");
        do_reset();
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == 0, "R10 cleared", lane(c), 0);
        for (int n = 0; n < WIN; n++) begin
            int d;
            d = dc_of((n / 2) % NCH);
            push((n % 2 == 0) ? -d : d, 1'b1, "R10 realigned");
        end
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == dc_of(c), "R10 dc level", lane(c), dc_of(c));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule